// File: doc/BRIEF.md
# Tone Classification Output Qualifier

This block sits behind a tone analyser that reports, once per analysis frame, which kinds of energy it saw on the line. The frame is nominally 7 ms. The reported kinds are call-progress band energy, energy in the 620 Hz band, a special information tone, a fax/modem low or high tone, and speech-like activity. A further flag says whether the signal is a single tone or a pair of tones. The block turns those per-frame flags into one stable 4-bit category code that a host can read. It also raises a one-cycle strobe whenever that code changes.

A category is not reported until it has been seen for enough consecutive frames. Silence does not clear the output at once. The code falls back to "no signal" only after a run of silent frames longer than a timeout. For special information and fax/modem tones, a short dropout in the middle of qualification is bridged. In the same situation, a call-progress or speech candidate restarts its count. Frame counts, the timeout and the bridge length are parameters, and bridging can be removed at elaboration.

Top module: `tone_qual`

## Requirements
- R1: A synchronous active-high `rst` forces `code_o` to 0000 and `code_chg_o` to 0, and clears the candidate, consistency and silence counters, so that qualification after reset starts from zero.
- R2: Each frame is classified by priority, highest first:
  - fax high (`in_fxhi`) gives 1000;
  - fax low (`in_fxlo`) gives 1100;
  - special information (`in_sit`) gives 0100;
  - call-progress band (`in_cpb`) gives 0101 if single and 0111 if single with 620 Hz, and 0001 if dual and 0011 if dual with 620 Hz;
  - speech activity (`in_voice`) gives 0110 if single and 0010 otherwise;
  - no flag set gives 0000.
- R3: The codes 1001, 1010, 1011, 1101, 1110 and 1111 never appear on `code_o`.
- R4: A non-zero category reaches `code_o` only in the frame where it has been the candidate for QUAL_FRAMES (default 21) consecutive frames. Any frame whose category differs from the candidate restarts the count at 1.
- R5: A run of silent frames holds `code_o` for up to GAP_TIMEOUT (default 12) frames. The frame that makes the run GAP_TIMEOUT+1 long sets `code_o` to 0000.
- R6: While the candidate is 0100, 1000 or 1100, the first BRIDGE_FRAMES (default 2) silent frames of a run count as frames of that candidate. A further silent frame makes "no signal" the candidate. Silent frames never bridge call-progress or speech candidates.
- R7: `code_chg_o` is high for exactly the one clock after each change of `code_o`, and low otherwise.
- R8: Flag inputs are ignored, and `code_o` cannot change, in any cycle without `frame_stb`. The code is updated one clock after a frame strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse marking a new analysis frame |
| in_cpb | input | 1 | Call-progress band energy this frame |
| in_f620 | input | 1 | 620 Hz band energy this frame |
| in_sit | input | 1 | Special information tone this frame |
| in_fxlo | input | 1 | Fax/modem low tone this frame |
| in_fxhi | input | 1 | Fax/modem high tone this frame |
| in_voice | input | 1 | Speech or other non-call-progress activity |
| in_single | input | 1 | Signal is a single tone (else dual) |
| code_o | output | 4 | Qualified category code |
| code_chg_o | output | 1 | One-cycle pulse after `code_o` changes |

## Verification
The bench builds the block with its default parameters:
- 21 qualifying frames;
- a 12-frame silence timeout;
- a 2-frame bridge, with bridging enabled.

With a frame strobe every fourth clock, the bench can exercise both sides of each window. Qualification is tested at frame 20 and frame 21. The silence timeout is tested with 12 silent frames, which hold the code, and 13, which clear it. The bridge is tested with 2 bridged dropouts and with 3 dropouts that restart the count. Flag noise between strobes exercises the rule that only strobed frames count.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

   typedef logic [3:0] code_t;

   localparam code_t CAT_NONE      = 4'b0000;
   localparam code_t CAT_CP_DUAL   = 4'b0001;
   localparam code_t CAT_VOICE     = 4'b0010;
   localparam code_t CAT_CP_DUAL_H = 4'b0011;
   localparam code_t CAT_SIT       = 4'b0100;
   localparam code_t CAT_CP_SGL    = 4'b0101;
   localparam code_t CAT_VOICE_SGL = 4'b0110;
   localparam code_t CAT_CP_SGL_H  = 4'b0111;
   localparam code_t CAT_FAX_HI    = 4'b1000;
   localparam code_t CAT_FAX_LO    = 4'b1100;

   // Categories whose short dropouts may be bridged
   function automatic logic cat_bridgeable(input code_t c);
      return (c == CAT_SIT) || (c == CAT_FAX_HI) || (c == CAT_FAX_LO);
   endfunction

   // Codes that must never be emitted
   function automatic logic cat_reserved(input code_t c);
      return c[3] && (c[1:0] != 2'b00);
   endfunction

endpackage

// File: rtl/tcq_classify.sv
module tcq_classify
   import tcq_pkg::*;
(
   input  logic  cpb,
   input  logic  f620,
   input  logic  sit,
   input  logic  fxlo,
   input  logic  fxhi,
   input  logic  voice,
   input  logic  single,
   output code_t raw_cat
);

   code_t cp_code;
   code_t vo_code;

   // call-progress sub-code: single/dual crossed with 620 Hz presence
   always_comb begin
      unique case ({single, f620})
         2'b00:   cp_code = CAT_CP_DUAL;
         2'b01:   cp_code = CAT_CP_DUAL_H;
         2'b10:   cp_code = CAT_CP_SGL;
         default: cp_code = CAT_CP_SGL_H;
      endcase
   end

   always_comb vo_code = single ? CAT_VOICE_SGL : CAT_VOICE;

   // fixed priority, highest first
   always_comb begin
      if (fxhi)       raw_cat = CAT_FAX_HI;
      else if (fxlo)  raw_cat = CAT_FAX_LO;
      else if (sit)   raw_cat = CAT_SIT;
      else if (cpb)   raw_cat = cp_code;
      else if (voice) raw_cat = vo_code;
      else            raw_cat = CAT_NONE;
   end

endmodule

// File: rtl/tcq_gap.sv
module tcq_gap
   import tcq_pkg::*;
#(
   parameter int GAP_TIMEOUT   = 12,
   parameter int BRIDGE_FRAMES = 2,
   parameter bit BRIDGE_EN     = 1'b1
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  frame_stb,
   input  code_t raw_cat,
   input  code_t cand,
   output code_t eff_cat,
   output logic  gap_expired
);

   localparam int GAP_MAX = GAP_TIMEOUT + 1;
   localparam int GAP_W   = $clog2(GAP_MAX + 1);
   localparam logic [GAP_W-1:0] GAP_MAX_L = GAP_W'(GAP_MAX);

   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] gap_nxt;
   logic             silent;

   assign silent = (raw_cat == CAT_NONE);

   // saturating silent-frame run length including this frame
   always_comb begin
      if (!silent)               gap_nxt = '0;
      else if (gap_q == GAP_MAX_L) gap_nxt = gap_q;
      else                       gap_nxt = gap_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)            gap_q <= '0;
      else if (frame_stb) gap_q <= gap_nxt;
   end

   assign gap_expired = silent && (gap_nxt == GAP_MAX_L);

   generate
      if (BRIDGE_EN) begin : g_bridge
         localparam logic [GAP_W-1:0] BRIDGE_L = GAP_W'(BRIDGE_FRAMES);
         logic take;
         assign take    = silent && (gap_nxt <= BRIDGE_L) && cat_bridgeable(cand);
         assign eff_cat = take ? cand : raw_cat;
      end else begin : g_nobridge
         assign eff_cat = raw_cat;
      end
   endgenerate

endmodule

// File: rtl/tcq_consist.sv
module tcq_consist
   import tcq_pkg::*;
#(
   parameter int QUAL_FRAMES = 21
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  frame_stb,
   input  code_t eff_cat,
   output code_t cand,
   output logic  qual_hit
);

   localparam int CNT_W = $clog2(QUAL_FRAMES + 1);
   localparam logic [CNT_W-1:0] QUAL_L = CNT_W'(QUAL_FRAMES);

   code_t            cand_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             same;

   assign same = (eff_cat == cand_q);

   // restart at one on a new candidate, saturate at the limit
   always_comb begin
      if (!same)              cnt_nxt = CNT_W'(1);
      else if (cnt_q >= QUAL_L) cnt_nxt = QUAL_L;
      else                    cnt_nxt = cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cand_q <= CAT_NONE;
         cnt_q  <= '0;
      end else if (frame_stb) begin
         cand_q <= eff_cat;
         cnt_q  <= cnt_nxt;
      end
   end

   assign cand     = cand_q;
   assign qual_hit = (cnt_nxt >= QUAL_L);

endmodule

// File: rtl/tone_qual.sv
module tone_qual
   import tcq_pkg::*;
#(
   parameter int QUAL_FRAMES   = 21,
   parameter int GAP_TIMEOUT   = 12,
   parameter int BRIDGE_FRAMES = 2,
   parameter bit BRIDGE_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       frame_stb,
   input  logic       in_cpb,
   input  logic       in_f620,
   input  logic       in_sit,
   input  logic       in_fxlo,
   input  logic       in_fxhi,
   input  logic       in_voice,
   input  logic       in_single,
   output logic [3:0] code_o,
   output logic       code_chg_o
);

   // elaboration-time parameter checks
   generate
      if (QUAL_FRAMES < 1) begin : g_bad_qual
         $error("QUAL_FRAMES must be at least 1");
      end
      if (GAP_TIMEOUT < 1) begin : g_bad_gap
         $error("GAP_TIMEOUT must be at least 1");
      end
      if (BRIDGE_FRAMES < 0 || BRIDGE_FRAMES > GAP_TIMEOUT) begin : g_bad_bridge
         $error("BRIDGE_FRAMES must lie in 0..GAP_TIMEOUT");
      end
   endgenerate

   code_t raw_cat;
   code_t eff_cat;
   code_t cand;
   logic  qual_hit;
   logic  gap_expired;
   code_t code_q;
   logic  chg_q;

   tcq_classify u_cls (
      .cpb     (in_cpb),
      .f620    (in_f620),
      .sit     (in_sit),
      .fxlo    (in_fxlo),
      .fxhi    (in_fxhi),
      .voice   (in_voice),
      .single  (in_single),
      .raw_cat (raw_cat)
   );

   tcq_gap #(
      .GAP_TIMEOUT   (GAP_TIMEOUT),
      .BRIDGE_FRAMES (BRIDGE_FRAMES),
      .BRIDGE_EN     (BRIDGE_EN)
   ) u_gap (
      .clk         (clk),
      .rst         (rst),
      .frame_stb   (frame_stb),
      .raw_cat     (raw_cat),
      .cand        (cand),
      .eff_cat     (eff_cat),
      .gap_expired (gap_expired)
   );

   tcq_consist #(
      .QUAL_FRAMES (QUAL_FRAMES)
   ) u_cons (
      .clk       (clk),
      .rst       (rst),
      .frame_stb (frame_stb),
      .eff_cat   (eff_cat),
      .cand      (cand),
      .qual_hit  (qual_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= CAT_NONE;
         chg_q  <= 1'b0;
      end else begin
         chg_q <= 1'b0;
         if (frame_stb) begin
            if (eff_cat != CAT_NONE && qual_hit) begin
               if (code_q != eff_cat) begin
                  code_q <= eff_cat;
                  chg_q  <= 1'b1;
               end
            end else if (gap_expired && code_q != CAT_NONE) begin
               code_q <= CAT_NONE;
               chg_q  <= 1'b1;
            end
         end
      end
   end

   assign code_o     = code_q;
   assign code_chg_o = chg_q;

endmodule

// File: rtl/tone_qual_chk.sv
module tone_qual_chk
   import tcq_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic       frame_stb,
   input logic       in_cpb,
   input logic       in_sit,
   input logic       in_fxlo,
   input logic       in_fxhi,
   input logic       in_voice,
   input logic [3:0] code_o,
   input logic       code_chg_o
);

   logic armed;
   always_ff @(posedge clk) armed <= !rst;

   // R3
   no_reserved_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !cat_reserved(code_o));

   // R7
   chg_marks_change_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      code_chg_o |-> (code_o != $past(code_o)));

   // R7
   quiet_when_stable_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !code_chg_o |-> $stable(code_o));

   // R8
   change_needs_frame_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      !$stable(code_o) |-> $past(frame_stb));

   // R5
   drop_needs_silence_chk: assert property (@(posedge clk) disable iff (rst || !armed)
      (code_o == CAT_NONE && $past(code_o) != CAT_NONE) |->
         !$past(in_cpb || in_sit || in_fxlo || in_fxhi || in_voice));

endmodule

bind tone_qual tone_qual_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .frame_stb  (frame_stb),
   .in_cpb     (in_cpb),
   .in_sit     (in_sit),
   .in_fxlo    (in_fxlo),
   .in_fxhi    (in_fxhi),
   .in_voice   (in_voice),
   .code_o     (code_o),
   .code_chg_o (code_chg_o)
);

// File: tb/tone_qual_tb.sv
module tone_qual_tb;

   localparam int Q   = 21;
   localparam int TO  = 12;
   localparam int BR  = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_stb = 1'b0;
   logic [6:0] fl = '0;   // {single, voice, fxhi, fxlo, sit, f620, cpb}
   logic [3:0] code_o;
   logic       code_chg_o;

   int vectors = 0;
   int fails   = 0;
   string cur_req = "R1";
   bit started = 1'b0;

   always #4 clk = ~clk;

   tone_qual #(.QUAL_FRAMES(Q), .GAP_TIMEOUT(TO), .BRIDGE_FRAMES(BR), .BRIDGE_EN(1'b1)) u_dut (
      .clk(clk), .rst(rst), .frame_stb(frame_stb),
      .in_cpb(fl[0]), .in_f620(fl[1]), .in_sit(fl[2]), .in_fxlo(fl[3]),
      .in_fxhi(fl[4]), .in_voice(fl[5]), .in_single(fl[6]),
      .code_o(code_o), .code_chg_o(code_chg_o)
   );

   // behavioural reference
   function automatic int ref_cat(input logic [6:0] f);
      if (f[4]) return 8;
      if (f[3]) return 12;
      if (f[2]) return 4;
      if (f[0]) return f[6] ? (f[1] ? 7 : 5) : (f[1] ? 3 : 1);
      if (f[5]) return f[6] ? 6 : 2;
      return 0;
   endfunction

   int m_code = 0, m_cand = 0, m_cons = 0, m_gap = 0;
   bit m_chg = 0;

   always @(posedge clk) begin
      int raw, eff;
      started = 1'b1;
      if (rst) begin
         m_code = 0; m_cand = 0; m_cons = 0; m_gap = 0; m_chg = 0;
      end else begin
         m_chg = 0;
         if (frame_stb) begin
            raw = ref_cat(fl);
            m_gap = (raw == 0) ? m_gap + 1 : 0;
            eff = raw;
            if (raw == 0 && m_gap <= BR && (m_cand == 4 || m_cand == 8 || m_cand == 12))
               eff = m_cand;
            if (eff == m_cand) m_cons++;
            else begin m_cand = eff; m_cons = 1; end
            if (eff != 0 && m_cons >= Q) begin
               if (m_code != eff) begin m_code = eff; m_chg = 1; end
            end else if (raw == 0 && m_gap > TO && m_code != 0) begin
               m_code = 0; m_chg = 1;
            end
         end
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (started) begin
         vectors++;
         if (int'(code_o) != m_code) begin
            fails++;
            $display("FAIL %s code: got %b expected %b at %0t", cur_req, code_o, 4'(m_code), $time);
         end
         if (code_chg_o != m_chg) begin
            fails++;
            $display("FAIL R7 strobe (%s): got %b expected %b at %0t", cur_req, code_chg_o, m_chg, $time);
         end
         if (code_o[3] && code_o[1:0] != 2'b00) begin
            fails++;
            $display("FAIL R3 reserved code: got %b expected none of 1001..1111 at %0t", code_o, $time);
         end
      end
   end

   // frames with flag noise between strobes (R8)
   task automatic run(input logic [6:0] f, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); fl = f; frame_stb = 1'b1;
         @(negedge clk); frame_stb = 1'b0; fl = ~f;
         @(negedge clk); fl = {f[0], f[6:1]};
         @(negedge clk);
      end
   endtask

   task automatic check_code(input string req, input logic [3:0] exp);
      @(negedge clk);
      vectors++;
      if (code_o !== exp) begin
         fails++;
         $display("FAIL %s direct: got %b expected %b", req, code_o, exp);
      end
   endtask

   localparam logic [6:0] SIL   = 7'b0000000;
   localparam logic [6:0] CPD   = 7'b0000001;
   localparam logic [6:0] CPS   = 7'b1000001;
   localparam logic [6:0] CPS6  = 7'b1000011;
   localparam logic [6:0] CPD6  = 7'b0000011;
   localparam logic [6:0] SIT   = 7'b1000100;
   localparam logic [6:0] FXH   = 7'b1010000;
   localparam logic [6:0] FXL   = 7'b1001000;
   localparam logic [6:0] VOD   = 7'b0100000;
   localparam logic [6:0] VOS   = 7'b1100000;

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check_code("R1", 4'b0000);
      rst = 1'b0;
      // R4 qualification at exactly Q frames, restart on change
      cur_req = "R4";
      run(CPD, Q - 1);
      check_code("R4", 4'b0000);
      run(CPD, 1);
      check_code("R4", 4'b0001);
      run(CPS, 10);
      run(CPS6, Q + 1);
      check_code("R4", 4'b0111);
      // R5 hold for TO silent frames, clear at TO+1
      cur_req = "R5";
      run(SIL, TO);
      check_code("R5", 4'b0111);
      run(CPS6, 1);
      run(SIL, TO + 1);
      check_code("R5", 4'b0000);
      // R6 bridged dropout keeps SIT count, longer one restarts
      cur_req = "R6";
      run(SIT, 10); run(SIL, BR); run(SIT, Q - 10 - BR);
      check_code("R6", 4'b0100);
      run(SIL, TO + 1);
      run(FXH, 10); run(SIL, BR + 1); run(FXH, Q - 1);
      check_code("R6", 4'b0000);
      run(FXH, 1);
      check_code("R6", 4'b1000);
      run(CPD, 10); run(SIL, 1); run(CPD, Q - 11);
      check_code("R6", 4'b1000);
      // R2 priority and encodings
      cur_req = "R2";
      run(7'b1111111, Q); check_code("R2", 4'b1000);
      run(FXL | SIT | CPD, Q); check_code("R2", 4'b1100);
      run(SIT | CPD, Q); check_code("R2", 4'b0100);
      run(CPD6, Q); check_code("R2", 4'b0011);
      run(CPS, Q); check_code("R2", 4'b0101);
      run(VOS, Q); check_code("R2", 4'b0110);
      run(VOD, Q); check_code("R2", 4'b0010);
      run(CPD | VOD, Q); check_code("R2", 4'b0001);
      // R8 noise between strobes only; no strobes at all
      cur_req = "R8";
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); fl = 7'(i * 37);
      end
      check_code("R8", 4'b0001);
      // R1 mid-run reset clears counters
      cur_req = "R1";
      run(FXL, Q - 1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check_code("R1", 4'b0000);
      run(FXL, 1);
      check_code("R1", 4'b0000);
      run(FXL, Q - 1);
      check_code("R1", 4'b1100);
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule